// File: doc/BRIEF.md
# Active Cycle Counter with Compressed Encoding

This block measures how many cycles elapsed while transfer recording was active between two consecutive recorded control transfers. A cycle counts only when the active condition holds (the current privilege mode is enabled for recording and recording is not frozen) and the per-cycle tick is high. The running count is presented continuously as a floating-point style field: a small exponent plus a 12-bit mantissa. A validity flag goes with it and says whether the count covers the whole interval since the previous record.

The record store samples the three outputs in the cycle its qualified-transfer strobe is high. On that edge the counter restarts from zero and the flag becomes valid. A write to the recording control register or a clear command zeroes both the count and the flag. A separate strobe reports that active cycles may have gone uncounted. It drops only the flag. The count saturates at the largest encodable value instead of wrapping.

Top module: `ctr_cycle_meter`

## Requirements
- R1: While `rst_n` is low and in the first cycle after its release, `cc_exp_o` and `cc_mant_o` are 0 and `ccv_o` is 0.
- R2: The count rises by one on each clock edge where `tick_i` and `active_i` are both 1 and no strobe is present. If either input is 0 and no strobe is present, the outputs keep their value.
- R3: While the count is below 4096, `cc_exp_o` is 0 and `cc_mant_o` equals the count.
- R4: While the count is 4096 or more, `cc_exp_o` is the bit index of the count's most significant one minus 11. `cc_mant_o` holds the 12 count bits directly below that one. A count of 4096 gives exponent 1 and mantissa 0.
- R5: The outputs in a cycle with `xfer_i` high are the record's field. On the next cycle the count is 0 and `ccv_o` is 1, even if `tick_i` and `active_i` were high in the transfer cycle.
- R6: A cycle with `ctl_wr_i` or `clr_i` high leaves the count at 0 and `ccv_o` at 0 on the next cycle. This takes priority over `xfer_i`, so the first record after a clear reports `ccv_o` = 0.
- R7: A cycle with `lost_i` high leaves `ccv_o` at 0 on the next cycle and does not change the count. Together with `xfer_i`, the count restarts and the flag is 0.
- R8: The count stops at 2^(12 + 2^EXP_W − 1) − 1, where the exponent and mantissa are all ones, and holds there while ticks continue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| active_i | input | 1 | Mode enabled for recording and not frozen |
| tick_i | input | 1 | Per-cycle increment enable, same rate as the core cycle counter |
| xfer_i | input | 1 | Qualified transfer being recorded this cycle |
| ctl_wr_i | input | 1 | Write to the recording control register |
| clr_i | input | 1 | Clear command |
| lost_i | input | 1 | Active cycles may have gone uncounted |
| cc_exp_o | output | EXP_W | Exponent of the compressed count |
| cc_mant_o | output | MANT_W | Mantissa of the compressed count |
| ccv_o | output | 1 | Count-valid flag |

## Verification
The properties assume that every strobe is a clean, synchronous level sampled at the clock edge. They also assume that only strobes remove the validity flag, and that the mantissa increment check applies only while the exponent is zero. The stimulus changes inputs only on the falling edge. It raises each strobe for exactly one cycle, and it holds tick and active steady across long counting runs. This lets every expected output be derived from the number of rising edges seen. Saturation is exercised on a second instance with a narrow exponent, so the ceiling is reached within the run.

// File: rtl/ccnt_pkg.sv
// Shared sizing helpers for the active cycle counter.
// Assumes the mantissa is at least 2 bits and the exponent at least 1 bit.
package ccnt_pkg;
    // Counter width able to hold every value the exponent/mantissa pair encodes
    function automatic int cnt_width(input int mant_w, input int exp_w);
        return mant_w + (1 << exp_w) - 1;
    endfunction
endpackage

// File: rtl/ccnt_counter.sv
// Saturating up-counter with a synchronous zero request.
// Assumes zero_i has priority over inc_i; the count never wraps.
module ccnt_counter #(
    parameter int W = 27
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    input  logic         zero_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    // Count held cycles, restart on request, stop at the top value
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_o <= '0;
        else if (zero_i)
            cnt_o <= '0;
        else if (inc_i && (cnt_o != TOP))
            cnt_o <= cnt_o + 1'b1;
    end
endmodule

// File: rtl/ccnt_valid.sv
// Validity flag for the running count.
// Assumes kill_i wins over set_i when both are present.
module ccnt_valid (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic kill_i,
    output logic vld_o
);
    // Track whether the count covers the whole interval since the last record
    always_ff @(posedge clk) begin
        if (!rst_n)
            vld_o <= 1'b0;
        else if (kill_i)
            vld_o <= 1'b0;
        else if (set_i)
            vld_o <= 1'b1;
    end
endmodule

// File: rtl/ccnt_encode.sv
// Compresses a binary count into exponent and mantissa.
// Below 2^MANT_W the mantissa is the raw count and the exponent is 0.
// Above it the exponent is the leading-one index minus (MANT_W-1), and the
// mantissa holds the MANT_W bits just below the leading one.
// Assumes CNT_W = MANT_W + 2^EXP_W - 1, so every exponent fits in EXP_W bits.
module ccnt_encode #(
    parameter int MANT_W = 12,
    parameter int EXP_W  = 4,
    parameter int CNT_W  = MANT_W + (1 << EXP_W) - 1
) (
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [EXP_W-1:0]  exp_o,
    output logic [MANT_W-1:0] mant_o
);
    // One-hot leading-one flags for the bits that carry an exponent
    logic [CNT_W-1:MANT_W] lead;

    genvar g;
    generate
        for (g = MANT_W; g < CNT_W; g++) begin : g_lead
            if (g == CNT_W - 1) begin : g_top
                assign lead[g] = cnt_i[g];
            end else begin : g_mid
                assign lead[g] = cnt_i[g] & ~(|cnt_i[CNT_W-1:g+1]);
            end
        end
    endgenerate

    logic [CNT_W-1:0] shifted;

    // Turn the leading-one position into exponent and aligned mantissa
    always_comb begin
        exp_o   = '0;
        shifted = cnt_i;
        for (int i = MANT_W; i < CNT_W; i++) begin
            if (lead[i]) begin
                exp_o   = EXP_W'(i - (MANT_W - 1));
                shifted = cnt_i >> (i - MANT_W);
            end
        end
        mant_o = shifted[MANT_W-1:0];
    end
endmodule

// File: rtl/ctr_cycle_meter.sv
// Active cycle counter for transfer records.
// Counts ticks while recording is active and presents the count in
// compressed form with a validity flag. The record store samples the
// outputs in the cycle xfer_i is high.
// Assumes all strobes are synchronous to clk. A clear or a control write
// outranks a transfer. A lost-cycle report drops only the flag.
module ctr_cycle_meter #(
    parameter int MANT_W = 12,
    parameter int EXP_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active_i,
    input  logic              tick_i,
    input  logic              xfer_i,
    input  logic              ctl_wr_i,
    input  logic              clr_i,
    input  logic              lost_i,
    output logic [EXP_W-1:0]  cc_exp_o,
    output logic [MANT_W-1:0] cc_mant_o,
    output logic              ccv_o
);
    localparam int CNT_W = ccnt_pkg::cnt_width(MANT_W, EXP_W);

    logic [CNT_W-1:0] cnt;
    logic             wipe;
    logic             zero_req;
    logic             inc_req;

    // Decode strobes into counter and flag requests
    always_comb begin
        wipe     = clr_i | ctl_wr_i;
        zero_req = wipe | xfer_i;
        inc_req  = tick_i & active_i;
    end

    ccnt_counter #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc_i  (inc_req),
        .zero_i (zero_req),
        .cnt_o  (cnt)
    );

    ccnt_valid u_vld (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (xfer_i),
        .kill_i (wipe | lost_i),
        .vld_o  (ccv_o)
    );

    ccnt_encode #(.MANT_W(MANT_W), .EXP_W(EXP_W), .CNT_W(CNT_W)) u_enc (
        .cnt_i  (cnt),
        .exp_o  (cc_exp_o),
        .mant_o (cc_mant_o)
    );
endmodule

// File: rtl/ctr_cycle_meter_chk.sv
// Port-level checker for ctr_cycle_meter, attached by bind.
// Assumes strobes are sampled at the rising edge of clk.
module ctr_cycle_meter_chk #(
    parameter int MANT_W = 12,
    parameter int EXP_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              active_i,
    input logic              tick_i,
    input logic              xfer_i,
    input logic              ctl_wr_i,
    input logic              clr_i,
    input logic              lost_i,
    input logic [EXP_W-1:0]  cc_exp_o,
    input logic [MANT_W-1:0] cc_mant_o,
    input logic              ccv_o
);
    logic quiet;
    assign quiet = !xfer_i && !ctl_wr_i && !clr_i && !lost_i;

    // R1
    r1_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (cc_exp_o == '0) && (cc_mant_o == '0) && !ccv_o);

    // R2
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && !(tick_i && active_i)) |=> $stable(cc_exp_o) && $stable(cc_mant_o) && $stable(ccv_o));

    // R3
    step_small_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && tick_i && active_i && cc_exp_o == '0 && cc_mant_o != '1)
        |=> (cc_exp_o == '0) && (cc_mant_o == $past(cc_mant_o) + 1'b1));

    // R5
    xfer_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_i && !clr_i && !ctl_wr_i && !lost_i)
        |=> ccv_o && (cc_exp_o == '0) && (cc_mant_o == '0));

    // R6
    wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i || ctl_wr_i) |=> !ccv_o && (cc_exp_o == '0) && (cc_mant_o == '0));

    // R7
    lost_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lost_i |=> !ccv_o);

    // R5
    flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ccv_o) |-> $past(xfer_i));

    // R8
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && cc_exp_o == '1 && cc_mant_o == '1) |=> (cc_exp_o == '1) && (cc_mant_o == '1));
endmodule

bind ctr_cycle_meter ctr_cycle_meter_chk #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_chk (.*);

// File: tb/sim_ctr_cycle_meter.sv
module sim_ctr_cycle_meter;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic active_i = 1'b0, tick_i = 1'b0, xfer_i = 1'b0;
    logic ctl_wr_i = 1'b0, clr_i = 1'b0, lost_i = 1'b0;
    logic [3:0]  cc_exp_o;
    logic [11:0] cc_mant_o;
    logic        ccv_o;
    logic [1:0]  s_exp;
    logic [11:0] s_mant;
    logic        s_ccv;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctr_cycle_meter u0 (
        .clk(clk), .rst_n(rst_n), .active_i(active_i), .tick_i(tick_i),
        .xfer_i(xfer_i), .ctl_wr_i(ctl_wr_i), .clr_i(clr_i), .lost_i(lost_i),
        .cc_exp_o(cc_exp_o), .cc_mant_o(cc_mant_o), .ccv_o(ccv_o)
    );

    // Narrow exponent so the saturation ceiling (32767) is reachable
    ctr_cycle_meter #(.MANT_W(12), .EXP_W(2)) u_sat (
        .clk(clk), .rst_n(rst_n), .active_i(active_i), .tick_i(tick_i),
        .xfer_i(xfer_i), .ctl_wr_i(ctl_wr_i), .clr_i(clr_i), .lost_i(lost_i),
        .cc_exp_o(s_exp), .cc_mant_o(s_mant), .ccv_o(s_ccv)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference encoding built from the requirement text
    task automatic ref_enc(input int c, output int e, output int m);
        int p;
        if (c < 4096) begin
            e = 0; m = c;
        end else begin
            p = 0;
            while ((c >> (p + 1)) != 0) p++;
            e = p - 11;
            m = (c >> (p - 12)) % 4096;
        end
    endtask

    task automatic expect_count(input string tag, input int c, input int v);
        int e, m;
        ref_enc(c, e, m);
        chk({tag, " exp"}, int'(cc_exp_o), e);
        chk({tag, " mant"}, int'(cc_mant_o), m);
        chk({tag, " ccv"}, int'(ccv_o), v);
    endtask

    task automatic run(input int n, input logic tk, input logic ac);
        tick_i = tk; active_i = ac;
        repeat (n) @(negedge clk);
        tick_i = 1'b0; active_i = 1'b0;
    endtask

    task automatic pulse_clr();
        clr_i = 1'b1; @(negedge clk); clr_i = 1'b0;
    endtask

    task automatic pulse_xfer();
        xfer_i = 1'b1; @(negedge clk); xfer_i = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk); @(negedge clk);
        expect_count("R1 in reset", 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        expect_count("R1 after release", 0, 0);
    endtask

    task automatic t_gating();
        pulse_clr();
        run(100, 1'b1, 1'b1);
        expect_count("R2 R3 count 100", 100, 0);
        run(20, 1'b1, 1'b0);
        expect_count("R2 inactive hold", 100, 0);
        run(20, 1'b0, 1'b1);
        expect_count("R2 no tick hold", 100, 0);
    endtask

    task automatic t_large();
        pulse_clr();
        run(4095, 1'b1, 1'b1);
        expect_count("R3 count 4095", 4095, 0);
        run(1, 1'b1, 1'b1);
        chk("R4 4096 exp", int'(cc_exp_o), 1);
        chk("R4 4096 mant", int'(cc_mant_o), 0);
        run(5000 - 4096, 1'b1, 1'b1);
        expect_count("R4 count 5000", 5000, 0);
        run(15000, 1'b1, 1'b1);
        expect_count("R4 count 20000", 20000, 0);
    endtask

    task automatic t_xfer();
        pulse_clr();
        run(37, 1'b1, 1'b1);
        expect_count("R6 first record after clear", 37, 0);
        pulse_xfer();
        expect_count("R5 restart", 0, 1);
        run(10, 1'b1, 1'b1);
        expect_count("R5 count after xfer", 10, 1);
        tick_i = 1'b1; active_i = 1'b1; xfer_i = 1'b1;
        @(negedge clk);
        xfer_i = 1'b0; tick_i = 1'b0; active_i = 1'b0;
        expect_count("R5 xfer with tick", 0, 1);
    endtask

    task automatic t_clear();
        run(12, 1'b1, 1'b1);
        ctl_wr_i = 1'b1; @(negedge clk); ctl_wr_i = 1'b0;
        expect_count("R6 ctl write", 0, 0);
        pulse_xfer();
        run(5, 1'b1, 1'b1);
        xfer_i = 1'b1; clr_i = 1'b1; @(negedge clk); xfer_i = 1'b0; clr_i = 1'b0;
        expect_count("R6 clear over xfer", 0, 0);
    endtask

    task automatic t_lost();
        pulse_xfer();
        run(10, 1'b1, 1'b1);
        lost_i = 1'b1; @(negedge clk); lost_i = 1'b0;
        expect_count("R7 lost keeps count", 10, 0);
        pulse_xfer();
        run(3, 1'b1, 1'b1);
        xfer_i = 1'b1; lost_i = 1'b1; @(negedge clk); xfer_i = 1'b0; lost_i = 1'b0;
        expect_count("R7 lost with xfer", 0, 0);
    endtask

    task automatic t_sat();
        pulse_clr();
        run(33000, 1'b1, 1'b1);
        chk("R8 sat exp", int'(s_exp), 3);
        chk("R8 sat mant", int'(s_mant), 4095);
        run(50, 1'b1, 1'b1);
        chk("R8 sat hold exp", int'(s_exp), 3);
        chk("R8 sat hold mant", int'(s_mant), 4095);
    endtask

    initial begin
        t_reset();
        t_gating();
        t_large();
        t_xfer();
        t_clear();
        t_lost();
        t_sat();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule